// File: doc/BRIEF.md
# Power Controller with Masked Output Pins

This peripheral sits on a simple 32-bit register bus (address, write data, write strobe, read strobe, read data). It drives two general-purpose output pins and raises a system power-off line. The pins are set through a write-only register. In that register the upper half-word carries a per-pin write-enable, so software can change one pin without knowing the state of the other. Software cannot read the pins back.

Power-off is guarded by an arming sequence. Software first sets a soft-reset release flag and a main clock enable flag, each in its own register. Only then is a write of a request to the power-off register accepted. If the request arrives before both flags are set, it is dropped and a sticky error bit records the mistake. Once the power-off line is high, it stays high until the system reset. While it is high, the output pins are frozen.

Top module: `pwrctl_top`

## Requirements
- R1: A synchronous active-high reset clears both output pins, the power-off line, the read data, both arming flags and the error bit.
- R2: A write to byte offset 0x80 sets pin i (i = 0, 1) to write-data bit i only when write-data bit 16+i is 1. Without that enable bit, the pin keeps its previous value.
- R3: In a write to offset 0x80, every bit other than 0, 1, 16 and 17 is ignored.
- R4: A read of offset 0x80, or of any unmapped offset, returns zero. A write to an unmapped offset changes neither the pins, nor the power-off line, nor any register.
- R5: Offset 0x00 holds the soft-reset release flag and offset 0x04 holds the clock enable flag. Each is written from write-data bit 0 and reads back in bit 0, with all other bits zero.
- R6: A write to offset 0x50 with bit 0 = 1, made while both flags are already 1, raises the power-off line on the clock edge that captures the write. A write to 0x50 with bit 0 = 0 has no effect.
- R7: A power-off request made while either flag is 0 leaves the power-off line low and sets a sticky error bit. A read of 0x50 returns the error bit in bit 1 and the power-off state in bit 0.
- R8: Once high, the power-off line stays high until reset. While it is high, writes to offset 0x80 leave the pins unchanged.
- R9: Read data is registered. It holds the addressed value in the cycle after a read strobe, and it is zero after any cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| gpo | output | NUM_OUT | Output pins |
| sys_poweroff | output | 1 | System power-off request line |

## Verification
A wrong arming flag or a wrong error bit becomes visible only through the bus. It shows in the cycle after a read of 0x00, 0x04 or 0x50. Otherwise it shows when a power-off request is accepted or refused, and the power-off line then differs one cycle after the write. A corrupted pin register shows on the pins in the cycle after the faulty write. A frozen or released lock shows only when a later pin write is attempted after power-off. The bench therefore interleaves reads and pin writes with the arming steps, so that each of these faults reaches a port within one or two cycles.

// File: rtl/pwrctl_pkg.sv
package pwrctl_pkg;

  // Register byte offsets (compared on the full bus address)
  localparam logic [7:0] OFS_RSTREL = 8'h00;
  localparam logic [7:0] OFS_CLKEN  = 8'h04;
  localparam logic [7:0] OFS_POFF   = 8'h50;
  localparam logic [7:0] OFS_PINS   = 8'h80;

  // Bit position of the per-pin write-enable field in the pin register
  localparam int unsigned PIN_MASK_LSB = 16;

  // One select line per mapped register
  typedef struct packed {
    logic rstrel;
    logic clken;
    logic poff;
    logic pins;
  } regsel_t;

endpackage

// File: rtl/pwrctl_busdec.sv
module pwrctl_busdec
  import pwrctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output regsel_t           wsel,
  output regsel_t           rsel
);

  regsel_t hit;

  always_comb begin
    hit        = '0;
    hit.rstrel = (addr == ADDR_W'(OFS_RSTREL));
    hit.clken  = (addr == ADDR_W'(OFS_CLKEN));
    hit.poff   = (addr == ADDR_W'(OFS_POFF));
    hit.pins   = (addr == ADDR_W'(OFS_PINS));
  end

  assign wsel = wr ? hit : '0;
  assign rsel = rd ? hit : '0;

endmodule

// File: rtl/pwrctl_pins.sv
module pwrctl_pins #(
  parameter int unsigned NUM_OUT = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [NUM_OUT-1:0] val,
  input  logic [NUM_OUT-1:0] ena,
  output logic [NUM_OUT-1:0] pins
);

  // Each pin is an independent flop updated only under its own enable bit
  for (genvar g = 0; g < NUM_OUT; g++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst)
        pins[g] <= 1'b0;
      else if (we && ena[g])
        pins[g] <= val[g];
    end
  end

endmodule

// File: rtl/pwrctl_seq.sv
module pwrctl_seq (
  input  logic clk,
  input  logic rst,
  input  logic wr_rstrel,
  input  logic wr_clken,
  input  logic wr_poff,
  input  logic wbit,
  output logic rstrel_q,
  output logic clken_q,
  output logic poff_q,
  output logic err_q
);

  logic armed;
  logic req;

  assign armed = rstrel_q && clken_q;
  assign req   = wr_poff && wbit;

  always_ff @(posedge clk) begin
    if (rst) begin
      rstrel_q <= 1'b0;
      clken_q  <= 1'b0;
    end else begin
      if (wr_rstrel) rstrel_q <= wbit;
      if (wr_clken)  clken_q  <= wbit;
    end
  end

  // Power-off and error are sticky; only the system reset clears them
  always_ff @(posedge clk) begin
    if (rst) begin
      poff_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (req) begin
      if (armed) poff_q <= 1'b1;
      else       err_q  <= 1'b1;
    end
  end

endmodule

// File: rtl/pwrctl_top.sv
module pwrctl_top
  import pwrctl_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_OUT = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic               bus_wr,
  input  logic               bus_rd,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic [NUM_OUT-1:0] gpo,
  output logic               sys_poweroff
);

  localparam int unsigned MASK_MSB = PIN_MASK_LSB + NUM_OUT - 1;

  initial begin
    if (MASK_MSB >= DATA_W) $error("pin enable field does not fit the data width");
  end

  regsel_t wsel, rsel;
  logic    rstrel_q, clken_q, poff_q, err_q;
  logic    pins_we;
  logic [DATA_W-1:0] rd_next;

  pwrctl_busdec #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .wr   (bus_wr),
    .rd   (bus_rd),
    .wsel (wsel),
    .rsel (rsel)
  );

  pwrctl_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .wr_rstrel (wsel.rstrel),
    .wr_clken  (wsel.clken),
    .wr_poff   (wsel.poff),
    .wbit      (bus_wdata[0]),
    .rstrel_q  (rstrel_q),
    .clken_q   (clken_q),
    .poff_q    (poff_q),
    .err_q     (err_q)
  );

  // Pin writes are locked out once power-off has been granted
  assign pins_we = wsel.pins && !poff_q;

  pwrctl_pins #(.NUM_OUT(NUM_OUT)) u_pins (
    .clk  (clk),
    .rst  (rst),
    .we   (pins_we),
    .val  (bus_wdata[NUM_OUT-1:0]),
    .ena  (bus_wdata[MASK_MSB:PIN_MASK_LSB]),
    .pins (gpo)
  );

  // Read mux: pin register and unmapped offsets return zero
  always_comb begin
    rd_next = '0;
    if (rsel.rstrel) rd_next[0] = rstrel_q;
    if (rsel.clken)  rd_next[0] = clken_q;
    if (rsel.poff)   rd_next[1:0] = {err_q, poff_q};
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  assign sys_poweroff = poff_q;

endmodule

// File: rtl/pwrctl_chk.sv
module pwrctl_chk #(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_OUT = 2
) (
  input logic               clk,
  input logic               rst,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic [NUM_OUT-1:0] gpo,
  input logic               sys_poweroff
);

  logic pin_wr, poff_req;
  assign pin_wr   = bus_wr && (bus_addr == ADDR_W'(8'h80));
  assign poff_req = bus_wr && (bus_addr == ADDR_W'(8'h50)) && bus_wdata[0];

  // R1
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (gpo == '0 && !sys_poweroff && bus_rdata == '0));

  p_pins_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !pin_wr |=> $stable(gpo));

  p_pin0_masked_r2: assert property (@(posedge clk) disable iff (rst)
    (pin_wr && !sys_poweroff && !bus_wdata[16]) |=> $stable(gpo[0]));

  p_rise_needs_req_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_poweroff) |-> $past(poff_req));

  p_poff_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    sys_poweroff |=> sys_poweroff);

  p_pins_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    sys_poweroff |=> $stable(gpo));

  p_rdata_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));

endmodule

bind pwrctl_top pwrctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_OUT(NUM_OUT)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .bus_wr       (bus_wr),
  .bus_rd       (bus_rd),
  .bus_rdata    (bus_rdata),
  .gpo          (gpo),
  .sys_poweroff (sys_poweroff)
);

// File: tb/sim_pwrctl_top.sv
`timescale 1ns/1ps
module sim_pwrctl_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [1:0]  gpo;
  logic        sys_poweroff;

  int n_chk = 0;
  int n_err = 0;

  // reference model state
  logic [1:0]  m_gpo = '0;
  logic        m_f0 = 1'b0, m_f1 = 1'b0, m_poff = 1'b0, m_err = 1'b0;
  logic [31:0] m_rdata = '0;

  always #2 clk = ~clk;

  pwrctl_top u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .gpo(gpo), .sys_poweroff(sys_poweroff)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // advance one clock: update model at the edge, compare at the falling edge
  task automatic step();
    logic [31:0] nr;
    @(posedge clk);
    if (rst) begin
      m_gpo = '0; m_f0 = 0; m_f1 = 0; m_poff = 0; m_err = 0; m_rdata = '0;
    end else begin
      nr = '0;
      if (bus_rd) begin
        if (bus_addr == 8'h00) nr = {31'b0, m_f0};
        else if (bus_addr == 8'h04) nr = {31'b0, m_f1};
        else if (bus_addr == 8'h50) nr = {30'b0, m_err, m_poff};
      end
      if (bus_wr) begin
        if (bus_addr == 8'h00) m_f0 = bus_wdata[0];
        else if (bus_addr == 8'h04) m_f1 = bus_wdata[0];
        else if (bus_addr == 8'h50) begin
          if (bus_wdata[0]) begin
            if (m_f0 && m_f1) m_poff = 1'b1;
            else m_err = 1'b1;
          end
        end else if (bus_addr == 8'h80 && !m_poff) begin
          for (int i = 0; i < 2; i++)
            if (bus_wdata[16+i]) m_gpo[i] = bus_wdata[i];
        end
      end
      m_rdata = nr;
    end
    @(negedge clk);
    check("R2 pins vs model", {30'b0, gpo}, {30'b0, m_gpo});
    check("R6 power-off vs model", {31'b0, sys_poweroff}, {31'b0, m_poff});
    check("R9 read data vs model", bus_rdata, m_rdata);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step();
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    step();
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    @(negedge clk);
    step(); step();
    rst = 1'b0;
    step();
    // R1: reset state
    check("R1 pins after reset", {30'b0, gpo}, 32'h0);
    check("R1 power-off after reset", {31'b0, sys_poweroff}, 32'h0);
    rd(8'h00, d); check("R1 release flag after reset", d, 32'h0);
    rd(8'h50, d); check("R1 error/power-off after reset", d, 32'h0);

    // R2: masked pin writes
    wr(8'h80, 32'h0003_0003); check("R2 both pins set", {30'b0, gpo}, 32'h3);
    wr(8'h80, 32'h0000_0000); check("R2 no enables holds", {30'b0, gpo}, 32'h3);
    wr(8'h80, 32'h0001_0000); check("R2 clear pin0 only", {30'b0, gpo}, 32'h2);
    wr(8'h80, 32'h0002_0001); check("R2 clear pin1, pin0 unenabled", {30'b0, gpo}, 32'h0);

    // R3: other bits ignored
    wr(8'h80, 32'hFFFC_FFFC); check("R3 stray bits ignored", {30'b0, gpo}, 32'h0);
    wr(8'h80, 32'hFFFF_FFFD); check("R3 stray bits with enables", {30'b0, gpo}, 32'h1);

    // R4: write-only pin register, unmapped offsets
    rd(8'h80, d); check("R4 pin register reads zero", d, 32'h0);
    rd(8'h40, d); check("R4 unmapped read zero", d, 32'h0);
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h84, 32'h0003_0002); check("R4 unmapped write keeps pins", {30'b0, gpo}, 32'h1);
    rd(8'h00, d); check("R4 unmapped write keeps flag", d, 32'h0);
    rd(8'h50, d); check("R4 unmapped write keeps power-off", d, 32'h0);

    // R9: read data clears after an idle cycle
    rd(8'h00, d); step(); check("R9 idle read data zero", bus_rdata, 32'h0);

    // R7: premature requests
    wr(8'h50, 32'h1); check("R7 refused without flags", {31'b0, sys_poweroff}, 32'h0);
    rd(8'h50, d); check("R7 error bit set", d, 32'h2);
    wr(8'h00, 32'h1);
    wr(8'h50, 32'h1); check("R7 refused with one flag", {31'b0, sys_poweroff}, 32'h0);

    // R5: flag registers
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, d); check("R5 release flag reads 1", d, 32'h1);
    wr(8'h04, 32'h1); rd(8'h04, d); check("R5 clock flag reads 1", d, 32'h1);
    wr(8'h04, 32'hFFFF_FFFE); rd(8'h04, d); check("R5 clock flag cleared", d, 32'h0);
    wr(8'h04, 32'h1);

    // R6: armed request
    wr(8'h50, 32'h0); check("R6 bit0=0 no effect", {31'b0, sys_poweroff}, 32'h0);
    wr(8'h50, 32'h1); check("R6 power-off raised", {31'b0, sys_poweroff}, 32'h1);

    // R8: sticky power-off, pins frozen
    wr(8'h80, 32'h0003_0002); check("R8 pins frozen", {30'b0, gpo}, 32'h1);
    wr(8'h00, 32'h0); step(); step();
    check("R8 power-off held", {31'b0, sys_poweroff}, 32'h1);
    rd(8'h50, d); check("R7 error sticky with power-off", d, 32'h3);
    rst = 1'b1; step(); rst = 1'b0; step();
    check("R8 reset drops power-off", {31'b0, sys_poweroff}, 32'h0);
    check("R1 reset clears pins", {30'b0, gpo}, 32'h0);
    rd(8'h50, d); check("R1 reset clears error", d, 32'h0);

    summary();
    $finish;
  end

endmodule